// File: doc/BRIEF.md
# Adaptive Crypto Primitive Reconfiguration Supervisor

This block supervises a reconfigurable cryptographic engine and decides which configuration it should run. Each accepted sample carries a battery level and a link-quality figure. The block averages these samples over fixed windows of four. At the end of each window, a hysteresis policy decides one of two things: keep the current parameter set, or request a different one. A lower-throughput, energy-saving set is chosen when energy or link quality degrades. The full-throughput set is restored only when both figures are clearly healthy again. A "hold performance" input freezes the current parameter set whenever throughput must be guaranteed.

A security alarm input overrides the performance policy. When the alarm is taken, the block does three things at once: it stalls the engine's I/O, it requests a trusted configuration, and it restarts the reload timer. The stall can only end when that trusted reload has finished. The block does not load any real bitstream. Instead it models each reload as a transfer of one byte per clock cycle. A busy flag stays high for exactly as many cycles as the selected image has bytes, and no new policy decision is issued while the flag is high.

Top module: `prim_reconf_ctrl`

## Requirements
- R1: After reset the configuration word is the full-throughput set (0x1C), busy and stall are low, ready is high and no request is pulsed.
- R2: The configuration word `cfg_o` packs key-size code in bits 6:5, throughput level in bits 4:3 and pipeline stage count in bits 2:0. The full-throughput set is 0x1C (key 0, level 3, 4 stages), the energy-saving set is 0x0A (key 0, level 1, 2 stages) and the trusted set is 0x4B (key 2, level 1, 3 stages).
- R3: Every fourth accepted sample closes a window. The per-input average is the window sum shifted right by two, and the decision it feeds takes effect at the clock edge after the window's last sample.
- R4: From the full-throughput set, the block switches to energy-saving when either average is below 60. From energy-saving, it returns to full-throughput only when both averages are at least 100. From the trusted set, it goes to full-throughput if both are at least 100, to energy-saving if either is below 60, and otherwise stays.
- R5: While `hold_perf_i` is high at a decision edge, the configuration word does not change and no request is pulsed.
- R6: Every configuration change pulses `req_o` for one cycle and raises busy for exactly the image size in cycles: 24 for full-throughput, 16 for energy-saving and 32 for trusted.
- R7: A window that completes while busy is high is discarded and causes no later change.
- R8: An alarm taken while not stalled sets stall, pulses `req_o` together with `req_trusted_o`, selects the trusted set and restarts a 32-cycle load. This pre-empts any load in progress and wins over a decision at the same edge.
- R9: Stall stays high until the trusted load completes, and it falls at the same edge as busy. An alarm that arrives while stalled is ignored.
- R10: `ready_o` is high exactly when both busy and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid_i | input | 1 | Accept one battery/link sample this cycle |
| battery_i | input | 8 | Battery level sample |
| chan_i | input | 8 | Channel quality sample |
| hold_perf_i | input | 1 | Guarantee throughput: freeze performance-driven changes |
| alarm_i | input | 1 | Irregular activity detected |
| cfg_o | output | 7 | Selected configuration word (layout in R2) |
| req_o | output | 1 | One-cycle reconfiguration request |
| req_trusted_o | output | 1 | Request is a trusted reload |
| busy_o | output | 1 | Modelled configuration transfer in progress |
| stall_o | output | 1 | Engine I/O stalled for security |
| ready_o | output | 1 | Engine usable: no pending load, no stall |

## Verification
A wrong window count or a wrong averaging shift shows up at the ports as a request that comes one or more samples early or late, or as a request that comes when it should not. It is seen at the edge after the fourth sample. A timer that loads the wrong byte count moves the falling edge of busy and ready away from the expected cycle. A wrong priority between the alarm and the policy shows up as a non-trusted request or a missing stall on the very next cycle. Because the reference model is compared with every output on every clock, each such fault is visible within one cycle of the edge where the state first diverges.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        MODE_FAST = 2'd0,
        MODE_ECO  = 2'd1,
        MODE_SAFE = 2'd2
    } prc_mode_e;

    typedef struct packed {
        logic [1:0] key_sz;
        logic [1:0] thru;
        logic [2:0] stages;
    } prc_cfg_t;

    localparam int CFG_W = $bits(prc_cfg_t);

    function automatic prc_cfg_t cfg_of(prc_mode_e m);
        prc_cfg_t c;
        case (m)
            MODE_ECO:  c = '{key_sz: 2'd0, thru: 2'd1, stages: 3'd2};
            MODE_SAFE: c = '{key_sz: 2'd2, thru: 2'd1, stages: 3'd3};
            default:   c = '{key_sz: 2'd0, thru: 2'd3, stages: 3'd4};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/prc_observer.sv
module prc_observer #(
    parameter int SAMPLE_W = 8,
    parameter int WIN_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid_i,
    input  logic [SAMPLE_W-1:0] bat_i,
    input  logic [SAMPLE_W-1:0] chq_i,
    output logic                avg_valid_o,
    output logic [SAMPLE_W-1:0] avg_bat_o,
    output logic [SAMPLE_W-1:0] avg_chq_o
);
    localparam int SUM_W = SAMPLE_W + WIN_LOG2;

    logic [WIN_LOG2-1:0] cnt_q;
    logic [SUM_W-1:0]    bat_sum_q, chq_sum_q;
    logic [SUM_W-1:0]    bat_nxt, chq_nxt;
    logic                last;

    assign bat_nxt = bat_sum_q + {{WIN_LOG2{1'b0}}, bat_i};
    assign chq_nxt = chq_sum_q + {{WIN_LOG2{1'b0}}, chq_i};
    assign last    = &cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            bat_sum_q   <= '0;
            chq_sum_q   <= '0;
            avg_valid_o <= 1'b0;
            avg_bat_o   <= '0;
            avg_chq_o   <= '0;
        end else begin
            avg_valid_o <= 1'b0;
            if (sample_valid_i) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    avg_bat_o   <= bat_nxt[SUM_W-1:WIN_LOG2];
                    avg_chq_o   <= chq_nxt[SUM_W-1:WIN_LOG2];
                    avg_valid_o <= 1'b1;
                    bat_sum_q   <= '0;
                    chq_sum_q   <= '0;
                end else begin
                    bat_sum_q <= bat_nxt;
                    chq_sum_q <= chq_nxt;
                end
            end
        end
    end

    AST_AVG_SPACED: assert property (@(posedge clk) disable iff (rst)
        avg_valid_o |=> !avg_valid_o); // R3

endmodule

// File: rtl/prc_policy.sv
module prc_policy
    import prc_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int BAT_LO   = 60,
    parameter int BAT_HI   = 100,
    parameter int CHQ_LO   = 60,
    parameter int CHQ_HI   = 100
) (
    input  prc_mode_e           mode_i,
    input  logic [SAMPLE_W-1:0] avg_bat_i,
    input  logic [SAMPLE_W-1:0] avg_chq_i,
    input  logic                hold_i,
    output logic                change_o,
    output prc_mode_e           next_mode_o
);
    logic degraded, healthy;

    assign degraded = (avg_bat_i <  SAMPLE_W'(BAT_LO)) || (avg_chq_i <  SAMPLE_W'(CHQ_LO));
    assign healthy  = (avg_bat_i >= SAMPLE_W'(BAT_HI)) && (avg_chq_i >= SAMPLE_W'(CHQ_HI));

    always_comb begin
        next_mode_o = mode_i;
        if (!hold_i) begin
            case (mode_i)
                MODE_FAST: if (degraded) next_mode_o = MODE_ECO;
                MODE_ECO:  if (healthy)  next_mode_o = MODE_FAST;
                MODE_SAFE: begin
                    if (healthy)       next_mode_o = MODE_FAST;
                    else if (degraded) next_mode_o = MODE_ECO;
                end
                default: next_mode_o = mode_i;
            endcase
        end
        change_o = (next_mode_o != mode_i);
    end

endmodule

// File: rtl/prc_xfer_timer.sv
module prc_xfer_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] bytes_i,
    output logic             busy_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    assign done_o = busy_o && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt_q  <= bytes_i - 1'b1;
        end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    AST_BUSY_PERSIST: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q != '0) |=> busy_o); // R6

endmodule

// File: rtl/prim_reconf_ctrl.sv
module prim_reconf_ctrl
    import prc_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int WIN_LOG2    = 2,
    parameter int BAT_LO      = 60,
    parameter int BAT_HI      = 100,
    parameter int CHQ_LO      = 60,
    parameter int CHQ_HI      = 100,
    parameter int BYTES_FAST  = 24,
    parameter int BYTES_ECO   = 16,
    parameter int BYTES_SAFE  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid_i,
    input  logic [SAMPLE_W-1:0] battery_i,
    input  logic [SAMPLE_W-1:0] chan_i,
    input  logic                hold_perf_i,
    input  logic                alarm_i,
    output logic [CFG_W-1:0]    cfg_o,
    output logic                req_o,
    output logic                req_trusted_o,
    output logic                busy_o,
    output logic                stall_o,
    output logic                ready_o
);
    localparam int MAX_BYTES = (BYTES_FAST > BYTES_ECO)
                             ? ((BYTES_FAST > BYTES_SAFE) ? BYTES_FAST : BYTES_SAFE)
                             : ((BYTES_ECO  > BYTES_SAFE) ? BYTES_ECO  : BYTES_SAFE);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    prc_mode_e           mode_q, next_mode, load_mode;
    logic                avg_valid, change;
    logic [SAMPLE_W-1:0] avg_bat, avg_chq;
    logic                xfer_done, start;
    logic                take_alarm, take_clear, take_perf;
    logic [CNT_W-1:0]    load_bytes;

    prc_observer #(.SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)) u_obs (
        .clk            (clk),
        .rst            (rst),
        .sample_valid_i (sample_valid_i),
        .bat_i          (battery_i),
        .chq_i          (chan_i),
        .avg_valid_o    (avg_valid),
        .avg_bat_o      (avg_bat),
        .avg_chq_o      (avg_chq)
    );

    prc_policy #(
        .SAMPLE_W(SAMPLE_W), .BAT_LO(BAT_LO), .BAT_HI(BAT_HI),
        .CHQ_LO(CHQ_LO), .CHQ_HI(CHQ_HI)
    ) u_pol (
        .mode_i      (mode_q),
        .avg_bat_i   (avg_bat),
        .avg_chq_i   (avg_chq),
        .hold_i      (hold_perf_i),
        .change_o    (change),
        .next_mode_o (next_mode)
    );

    // Priority: alarm, then end of trusted load, then performance policy.
    assign take_alarm = alarm_i && !stall_o;
    assign take_clear = !take_alarm && stall_o && xfer_done;
    assign take_perf  = !take_alarm && !take_clear && avg_valid && !busy_o && change;
    assign start      = take_alarm || take_perf;
    assign load_mode  = take_alarm ? MODE_SAFE : next_mode;

    always_comb begin
        case (load_mode)
            MODE_ECO:  load_bytes = CNT_W'(BYTES_ECO);
            MODE_SAFE: load_bytes = CNT_W'(BYTES_SAFE);
            default:   load_bytes = CNT_W'(BYTES_FAST);
        endcase
    end

    prc_xfer_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .bytes_i (load_bytes),
        .busy_o  (busy_o),
        .done_o  (xfer_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q        <= MODE_FAST;
            stall_o       <= 1'b0;
            req_o         <= 1'b0;
            req_trusted_o <= 1'b0;
        end else begin
            req_o         <= start;
            req_trusted_o <= take_alarm;
            if (start)      mode_q  <= load_mode;
            if (take_alarm) stall_o <= 1'b1;
            if (take_clear) stall_o <= 1'b0;
        end
    end

    assign cfg_o   = cfg_of(mode_q);
    assign ready_o = !busy_o && !stall_o;

    AST_ALARM_PRIO: assert property (@(posedge clk) disable iff (rst)
        (alarm_i && !stall_o) |=> (stall_o && req_trusted_o && req_o)); // R8

    AST_TRUSTED_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (cfg_o == CFG_W'(cfg_of(MODE_SAFE)))); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !xfer_done) |=> stall_o); // R9

    AST_NO_DECIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !alarm_i) |=> !req_o); // R7

    AST_REQ_STARTS_LOAD: assert property (@(posedge clk) disable iff (rst)
        req_o |-> busy_o); // R6

endmodule

// File: tb/prim_reconf_ctrl_bench.sv
module prim_reconf_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sv = 1'b0;
    logic [7:0] bat = '0;
    logic [7:0] chq = '0;
    logic       hold = 1'b0;
    logic       alarm = 1'b0;
    logic [6:0] cfg;
    logic       req, treq, busy, stall, ready;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    prim_reconf_ctrl u_prim_reconf_ctrl (
        .clk(clk), .rst(rst), .sample_valid_i(sv), .battery_i(bat), .chan_i(chq),
        .hold_perf_i(hold), .alarm_i(alarm), .cfg_o(cfg), .req_o(req),
        .req_trusted_o(treq), .busy_o(busy), .stall_o(stall), .ready_o(ready)
    );

    // ---------------- behavioural reference model ----------------
    int m_mode, m_left, m_n, m_sb, m_sc, m_ab, m_ac;
    bit m_avv, m_req, m_treq, m_stall;

    function automatic int code_of(int md);
        if (md == 1) return 'h0A;
        if (md == 2) return 'h4B;
        return 'h1C;
    endfunction

    function automatic int size_of(int md);
        if (md == 1) return 16;
        if (md == 2) return 32;
        return 24;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_left = 0; m_n = 0; m_sb = 0; m_sc = 0;
            m_ab = 0; m_ac = 0; m_avv = 0; m_req = 0; m_treq = 0; m_stall = 0;
        end else begin
            bit go;
            int want;
            go = 0;
            m_req = 0;
            m_treq = 0;
            if (alarm && !m_stall) begin
                m_stall = 1; m_mode = 2; m_req = 1; m_treq = 1; go = 1;
            end else if (m_stall && m_left == 1) begin
                m_stall = 0;
            end else if (m_avv && m_left == 0 && !hold) begin
                want = m_mode;
                if (m_mode == 0 && (m_ab < 60 || m_ac < 60)) want = 1;
                else if (m_mode != 0 && m_ab >= 100 && m_ac >= 100) want = 0;
                else if (m_mode == 2 && (m_ab < 60 || m_ac < 60)) want = 1;
                if (want != m_mode) begin
                    m_mode = want; m_req = 1; go = 1;
                end
            end
            if (go) m_left = size_of(m_mode);
            else if (m_left > 0) m_left--;
            m_avv = 0;
            if (sv) begin
                m_sb += bat; m_sc += chq; m_n++;
                if (m_n == 4) begin
                    m_ab = m_sb / 4; m_ac = m_sc / 4; m_avv = 1;
                    m_sb = 0; m_sc = 0; m_n = 0;
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            check("R2 cfg word vs model", int'(cfg), code_of(m_mode));
            check("R6 req pulse vs model", int'(req), int'(m_req));
            check("R8 trusted req vs model", int'(treq), int'(m_treq));
            check("R6 busy vs model", int'(busy), int'(m_left > 0));
            check("R9 stall vs model", int'(stall), int'(m_stall));
            check("R10 ready vs model", int'(ready), int'(m_left == 0 && !m_stall));
        end
    end

    task automatic send(int b, int c);
        bat = 8'(b); chq = 8'(c); sv = 1'b1;
        @(negedge clk);
        sv = 1'b0;
    endtask

    task automatic window(int b, int c);
        for (int i = 0; i < 4; i++) send(b, c);
    endtask

    task automatic wait_idle();
        while (busy || stall) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg after reset", int'(cfg), 'h1C);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 stall after reset", int'(stall), 0);
        check("R1 ready after reset", int'(ready), 1);
        check("R1 req after reset", int'(req), 0);

        // healthy window: no change
        window(200, 150);
        @(negedge clk);
        check("R4 healthy keeps fast", int'(req), 0);

        // mixed samples averaging to 50 -> energy-saving
        send(50, 200); send(40, 200); send(60, 200); send(50, 200);
        @(negedge clk);
        check("R3 req at edge after 4th sample", int'(req), 1);
        check("R2 eco code", int'(cfg), 'h0A);
        t0 = cyc;
        while (busy) @(negedge clk);
        check("R6 eco load length", cyc - t0, 16);

        // back to fast, then a degraded window arrives while busy
        window(120, 120);
        @(negedge clk);
        check("R4 both healthy returns fast", int'(cfg), 'h1C);
        window(10, 10);
        wait_idle();
        @(negedge clk);
        check("R7 window during busy discarded", int'(cfg), 'h1C);
        check("R10 ready after load", int'(ready), 1);

        // threshold boundaries
        window(60, 60);
        @(negedge clk);
        check("R4 avg 60 is not degraded", int'(req), 0);
        window(200, 59);
        @(negedge clk);
        check("R4 avg 59 degrades", int'(cfg), 'h0A);
        wait_idle();
        window(99, 200);
        @(negedge clk);
        check("R4 hysteresis holds eco at 99", int'(req), 0);
        window(100, 100);
        @(negedge clk);
        check("R4 avg 100 restores fast", int'(cfg), 'h1C);
        wait_idle();

        // guaranteed throughput
        hold = 1'b1;
        window(10, 10);
        @(negedge clk);
        check("R5 hold blocks change req", int'(req), 0);
        check("R5 hold keeps cfg", int'(cfg), 'h1C);
        hold = 1'b0;

        // alarm pre-empts a performance load
        window(10, 10);
        @(negedge clk);
        check("R6 eco req", int'(req), 1);
        repeat (2) @(negedge clk);
        alarm = 1'b1;
        @(negedge clk);
        alarm = 1'b0;
        t0 = cyc;
        check("R8 stall on alarm", int'(stall), 1);
        check("R8 trusted request", int'(treq), 1);
        check("R8 trusted code", int'(cfg), 'h4B);
        check("R10 not ready while stalled", int'(ready), 0);
        repeat (4) @(negedge clk);
        alarm = 1'b1;
        @(negedge clk);
        alarm = 1'b0;
        check("R9 alarm while stalled ignored", int'(req), 0);
        while (stall) @(negedge clk);
        check("R9 stall length equals trusted load", cyc - t0, 32);
        check("R9 busy falls with stall", int'(busy), 0);

        // alarm on the same edge as a decision
        window(10, 10);
        alarm = 1'b1;
        @(negedge clk);
        alarm = 1'b0;
        check("R8 alarm beats decision", int'(treq), 1);
        check("R8 cfg stays trusted", int'(cfg), 'h4B);
        wait_idle();

        // leaving the trusted set
        window(80, 80);
        @(negedge clk);
        check("R4 trusted kept in band", int'(cfg), 'h4B);
        window(30, 200);
        @(negedge clk);
        check("R4 trusted to eco", int'(cfg), 'h0A);
        wait_idle();
        repeat (2) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule